// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Vector Unit

This block is a packed SIMD arithmetic stage. Every lane takes signed operands `a` and `b` and the old destination value as accumulator. It forms twice the product of `a` and `b`, adds it to the accumulator or subtracts it, with the accumulator placed in the upper half of a double-width value. It rounds to nearest at the half-width boundary and returns the upper half, clamped to the signed lane range. The whole calculation is one wide add and one arithmetic shift: `(acc << (W-1)) ± a*b + (1 << (W-2))`, shifted right by `W-1`. Lanes are 16 or 32 bits wide, and all lanes of a 128-bit vector are computed in the same cycle.

An operation enters on a valid/ready handshake and comes out one cycle later as a registered beat on a second valid/ready pair. Back-pressure rules are simple. The input is ready whenever the output register is empty or is being drained in the same cycle. A beat that is not consumed keeps its data unchanged until `out_ready` is seen.

The active size and the maximum size are given in bytes. Bytes below the active size carry results. Bytes from the active size up to the maximum size are zero. Bytes at or above the maximum size return the old accumulator unchanged. A sticky saturation flag collects clamping events and is cleared only by a dedicated input. Each operation can choose not to update it.

Top module: `rdmac_vec`

## Requirements
- R1: With `in_esize` = 2'b01 the vector holds eight 16-bit lanes. Lane k occupies bits 16k+15:16k, so lane 0 is in bits 15:0. Each lane result is `((acc<<15) + a*b + (1<<14)) >>> 15`, computed with no loss of precision.
- R2: With `in_esize` = 2'b10 the vector holds four 32-bit lanes. Lane k occupies bits 32k+31:32k. Each lane result is `((acc<<31) + a*b + (1<<30)) >>> 31`.
- R3: A shifted result outside the signed lane range is clamped. A negative result becomes 0x8000 or 0x80000000, and a non-negative result becomes 0x7FFF or 0x7FFFFFFF. Each lane is clamped on its own.
- R4: With `in_sub` = 1 the product is subtracted instead of added. Rounding and clamping rules are unchanged.
- R5: With `in_sat_en` = 1, a clamp in any active lane sets `sat_flag` on the accepting edge. An operation never clears the flag.
- R6: With `in_sat_en` = 0, results are still clamped, but `sat_flag` keeps its value.
- R7: `sat_flag_clr` high at an edge clears `sat_flag`. If a flag-setting operation is accepted at the same edge, the flag is set.
- R8: `in_opr_bytes` and `in_max_bytes` are byte counts, multiples of 8, with opr ≤ max ≤ 16. For output byte i: i < opr gives the result, opr ≤ i < max gives zero, and i ≥ max gives the old accumulator byte. A lane at or beyond opr never sets `sat_flag`.
- R9: An accepted operation with `in_esize` of 2'b00 or 2'b11 produces no output beat. It leaves `out_vec` and `sat_flag` unchanged and raises `err_pulse` for exactly the next cycle.
- R10: `in_ready` equals `!out_valid || out_ready`. A valid operation accepted at an edge appears on `out_vec` with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, `out_vec` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_esize | input | 2 | Lane size: 01 = 16-bit, 10 = 32-bit, others rejected |
| in_sub | input | 1 | 1 = subtract product, 0 = add |
| in_sat_en | input | 1 | 1 = clamps update the sticky flag |
| in_opr_bytes | input | 5 | Active size in bytes |
| in_max_bytes | input | 5 | Maximum size in bytes |
| in_a | input | 128 | First multiplicand lanes |
| in_b | input | 128 | Second multiplicand lanes |
| in_acc | input | 128 | Old destination lanes (accumulator) |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_vec | output | 128 | New destination value |
| sat_flag_clr | input | 1 | Clears the sticky flag |
| sat_flag | output | 1 | Sticky cumulative saturation flag |
| err_pulse | output | 1 | One-cycle pulse for a rejected lane size |

## Verification
Every result, the flag update and the error pulse come from registers that load on the edge that accepts the operation, so each is due exactly one cycle after the handshake. The bench drives inputs on the falling edge and holds `in_valid` through one rising edge. It then reads `out_vec`, `sat_flag` and `err_pulse` on the next falling edge, which falls in the first cycle after acceptance. For back-pressure, the bench holds `out_ready` low for several cycles and checks that the beat is unchanged. It then checks that the waiting operation only appears one cycle after `out_ready` returns.

// File: rtl/rdmac_pkg.sv
package rdmac_pkg;
  typedef enum logic [1:0] {
    ESZ_RSV0 = 2'b00,
    ESZ_H    = 2'b01,
    ESZ_W    = 2'b10,
    ESZ_RSV3 = 2'b11
  } esize_e;
endpackage

// File: rtl/sqrdm_lane.sv
// One signed lane: widen, fuse doubling/rounding/accumulate into a single
// add, shift by W-1, then clamp to the signed W-bit range.
module sqrdm_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] acc,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int WW = 2 * W + 2;
  localparam logic [WW-1:0] RND = WW'(1) << (W - 2);

  logic signed [WW-1:0] ax, bx, cx, prod, sum, sh;
  logic [WW-W:0] hi;

  always_comb begin
    ax   = {{(WW-W){a[W-1]}}, a};
    bx   = {{(WW-W){b[W-1]}}, b};
    cx   = {{(WW-W){acc[W-1]}}, acc};
    cx   = cx <<< (W - 1);
    prod = ax * bx;
    sum  = sub ? (cx - prod + $signed(RND)) : (cx + prod + $signed(RND));
    sh   = sum >>> (W - 1);
    hi   = sh[WW-1:W-1];
    sat  = !((&hi) || !(|hi));
    if (sat) res = sh[WW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else     res = sh[W-1:0];
  end
endmodule

// File: rtl/sqrdm_tail.sv
// Per-byte merge: result below the active size, zero up to the maximum
// size, old destination above it.
module sqrdm_tail #(
  parameter int NB = 16,
  parameter int SW = 5
) (
  input  logic [NB*8-1:0] res,
  input  logic [NB*8-1:0] acc,
  input  logic [SW-1:0]   opr_bytes,
  input  logic [SW-1:0]   max_bytes,
  output logic [NB*8-1:0] merged
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_comb begin
      if (SW'(i) < opr_bytes)      merged[i*8 +: 8] = res[i*8 +: 8];
      else if (SW'(i) < max_bytes) merged[i*8 +: 8] = 8'h00;
      else                         merged[i*8 +: 8] = acc[i*8 +: 8];
    end
  end
endmodule

// File: rtl/rdmac_vec.sv
module rdmac_vec #(
  parameter int VEC_BITS = 128,
  parameter int SZW      = $clog2(VEC_BITS / 8) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_esize,
  input  logic                in_sub,
  input  logic                in_sat_en,
  input  logic [SZW-1:0]      in_opr_bytes,
  input  logic [SZW-1:0]      in_max_bytes,
  input  logic [VEC_BITS-1:0] in_a,
  input  logic [VEC_BITS-1:0] in_b,
  input  logic [VEC_BITS-1:0] in_acc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VEC_BITS-1:0] out_vec,
  input  logic                sat_flag_clr,
  output logic                sat_flag,
  output logic                err_pulse
);
  import rdmac_pkg::*;

  localparam int NB  = VEC_BITS / 8;
  localparam int N16 = VEC_BITS / 16;
  localparam int N32 = VEC_BITS / 32;

  logic [VEC_BITS-1:0] res16, res32, res_sel, merged;
  logic [N16-1:0]      sat16, act16;
  logic [N32-1:0]      sat32, act32;
  logic                size_ok, sat_any, accept;

  for (genvar k = 0; k < N16; k++) begin : g_h
    sqrdm_lane #(.W(16)) lane_i (
      .a(in_a[16*k +: 16]), .b(in_b[16*k +: 16]), .acc(in_acc[16*k +: 16]),
      .sub(in_sub), .res(res16[16*k +: 16]), .sat(sat16[k]));
    assign act16[k] = sat16[k] && (SZW'(2*k) < in_opr_bytes);
  end

  for (genvar k = 0; k < N32; k++) begin : g_w
    sqrdm_lane #(.W(32)) lane_i (
      .a(in_a[32*k +: 32]), .b(in_b[32*k +: 32]), .acc(in_acc[32*k +: 32]),
      .sub(in_sub), .res(res32[32*k +: 32]), .sat(sat32[k]));
    assign act32[k] = sat32[k] && (SZW'(4*k) < in_opr_bytes);
  end

  always_comb begin
    size_ok = (in_esize == ESZ_H) || (in_esize == ESZ_W);
    res_sel = (in_esize == ESZ_W) ? res32 : res16;
    sat_any = (in_esize == ESZ_W) ? (|act32) : (|act16);
  end

  sqrdm_tail #(.NB(NB), .SW(SZW)) tail_i (
    .res(res_sel), .acc(in_acc), .opr_bytes(in_opr_bytes),
    .max_bytes(in_max_bytes), .merged(merged));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      sat_flag  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= accept && !size_ok;
      if (accept && size_ok) begin
        out_valid <= 1'b1;
        out_vec   <= merged;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && size_ok && in_sat_en && sat_any) sat_flag <= 1'b1;
      else if (sat_flag_clr)                         sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rdmac_vec_chk.sv
module rdmac_vec_chk #(
  parameter int VEC_BITS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [1:0]          in_esize,
  input logic                in_sat_en,
  input logic                out_valid,
  input logic                out_ready,
  input logic [VEC_BITS-1:0] out_vec,
  input logic                sat_flag_clr,
  input logic                sat_flag,
  input logic                err_pulse
);
  logic take, bad;
  assign take = in_valid && in_ready;
  assign bad  = (in_esize == 2'b00) || (in_esize == 2'b11);

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));
  // R10
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_flag_clr |=> sat_flag);
  // R6
  flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_flag && (!take || !in_sat_en) |=> !sat_flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag_clr && !take |=> !sat_flag);
  // R9
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && bad |=> err_pulse);
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && bad) |=> !err_pulse);
endmodule

bind rdmac_vec rdmac_vec_chk #(.VEC_BITS(VEC_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_esize(in_esize), .in_sat_en(in_sat_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_vec(out_vec), .sat_flag_clr(sat_flag_clr),
  .sat_flag(sat_flag), .err_pulse(err_pulse));

// File: tb/rdmac_vec_tb_top.sv
`timescale 1ns/1ps
module rdmac_vec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_esize = 2'b01;
  logic in_sub = 1'b0, in_sat_en = 1'b1;
  logic [4:0] in_opr_bytes = 5'd16, in_max_bytes = 5'd16;
  logic [127:0] in_a = '0, in_b = '0, in_acc = '0;
  logic out_valid, out_ready = 1'b1;
  logic [127:0] out_vec;
  logic sat_flag_clr = 1'b0, sat_flag, err_pulse;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rdmac_vec dut_i (.*);

  // {a, b, acc, sub, expected lane, expected saturation}
  localparam logic [65:0] TBL [10] = '{
    {16'h4000, 16'h4000, 16'h0000, 1'b0, 16'h2000, 1'b0},
    {16'h8000, 16'h8000, 16'h0000, 1'b0, 16'h7FFF, 1'b1},
    {16'h8000, 16'h8000, 16'h0000, 1'b1, 16'h8000, 1'b0},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b0, 16'h7FFF, 1'b1},
    {16'h7FFF, 16'h7FFF, 16'h8000, 1'b1, 16'h8000, 1'b1},
    {16'h0001, 16'h4000, 16'h0000, 1'b0, 16'h0001, 1'b0},
    {16'h0001, 16'h3FFF, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'h0200, 16'h0300, 16'h0100, 1'b0, 16'h010C, 1'b0},
    {16'h0200, 16'h0300, 16'h0100, 1'b1, 16'h00F4, 1'b0},
    {16'hFFFF, 16'h4000, 16'h0005, 1'b0, 16'h0005, 1'b0}
  };

  function automatic logic [127:0] rep16(input logic [15:0] v);
    return {8{v}};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] es, input logic sb, input logic se,
                      input logic [4:0] op, input logic [4:0] mx,
                      input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_esize = es; in_sub = sb; in_sat_en = se;
    in_opr_bytes = op; in_max_bytes = mx; in_a = a; in_b = b; in_acc = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_flag_clr = 1'b1;
    @(negedge clk); sat_flag_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] exp, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R10
    check(!out_valid && !sat_flag && !err_pulse && in_ready, "R10 reset",
          {out_valid, sat_flag, err_pulse, in_ready}, 128'h1);

    // R1 R3 R4 R5: table of 16-bit lane cases, same case in every lane
    for (int i = 0; i < 10; i++) begin
      clear_flag();
      send(2'b01, TBL[i][17], 1'b1, 5'd16, 5'd16, rep16(TBL[i][65:50]),
           rep16(TBL[i][49:34]), rep16(TBL[i][33:18]));
      check(out_valid && out_vec == rep16(TBL[i][16:1]), "R1/R3/R4 lane16",
            out_vec, rep16(TBL[i][16:1]));
      check(sat_flag == TBL[i][0], "R5 flag", 128'(sat_flag), 128'(TBL[i][0]));
    end

    // R2 R3: 32-bit lanes, mixed cases per lane
    clear_flag();
    send(2'b10, 1'b0, 1'b1, 5'd16, 5'd16,
         {32'h0, 32'h80000000, 32'h80000000, 32'h40000000},
         {32'h0, 32'h80000000, 32'h80000000, 32'h40000000},
         {32'h12345678, 32'h0, 32'h0, 32'h0});
    exp = {32'h12345678, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h20000000};
    check(out_vec == exp, "R2/R3 lane32 add", out_vec, exp);
    check(sat_flag, "R5 lane32 flag", 128'(sat_flag), 128'h1);
    // R4 on 32-bit: -2^31 squared subtracted gives exact minimum, no clamp
    clear_flag();
    send(2'b10, 1'b1, 1'b1, 5'd16, 5'd16, {4{32'h80000000}},
         {4{32'h80000000}}, '0);
    check(out_vec == {4{32'h80000000}}, "R4 lane32 sub", out_vec,
          {4{32'h80000000}});
    check(!sat_flag, "R4 lane32 no clamp", 128'(sat_flag), 128'h0);

    // R1 packing: independent lanes, only lane 0 clamps
    clear_flag();
    send(2'b01, 1'b0, 1'b1, 5'd16, 5'd16, {112'h0, 16'h8000},
         {112'h0, 16'h8000}, {16'h1111, 96'h0, 16'h0});
    exp = {16'h1111, 96'h0, 16'h7FFF};
    check(out_vec == exp, "R1 lane packing", out_vec, exp);

    // R6: clamp without flag update
    clear_flag();
    send(2'b01, 1'b0, 1'b0, 5'd16, 5'd16, rep16(16'h8000), rep16(16'h8000), '0);
    check(out_vec == rep16(16'h7FFF), "R6 clamp", out_vec, rep16(16'h7FFF));
    check(!sat_flag, "R6 flag untouched", 128'(sat_flag), 128'h0);

    // R8: active half, zero up to max
    send(2'b01, 1'b0, 1'b1, 5'd8, 5'd16, rep16(16'h0200), rep16(16'h0300),
         rep16(16'h0100));
    exp = {64'h0, {4{16'h010C}}};
    check(out_vec == exp, "R8 tail zero", out_vec, exp);
    // R8: nothing active, bytes above max keep accumulator
    send(2'b01, 1'b0, 1'b1, 5'd0, 5'd8, rep16(16'h0200), rep16(16'h0300),
         rep16(16'h0100));
    exp = {{4{16'h0100}}, 64'h0};
    check(out_vec == exp, "R8 beyond max", out_vec, exp);
    // R8: clamping only in inactive lanes leaves the flag clear
    send(2'b01, 1'b0, 1'b1, 5'd8, 5'd16, {{4{16'h8000}}, {4{16'h0001}}},
         {{4{16'h8000}}, {4{16'h4000}}}, '0);
    exp = {64'h0, {4{16'h0001}}};
    check(out_vec == exp && !sat_flag, "R8 inactive sat",
          {out_vec[127:1], sat_flag}, {exp[127:1], 1'b0});

    // R5: flag not cleared by a non-saturating operation
    send(2'b01, 1'b0, 1'b1, 5'd16, 5'd16, rep16(16'h8000), rep16(16'h8000), '0);
    send(2'b01, 1'b0, 1'b1, 5'd16, 5'd16, '0, '0, '0);
    check(sat_flag, "R5 sticky", 128'(sat_flag), 128'h1);

    // R7: clear with simultaneous set keeps flag set
    @(negedge clk);
    sat_flag_clr = 1'b1; in_valid = 1'b1; in_esize = 2'b01; in_sat_en = 1'b1;
    in_sub = 1'b0; in_opr_bytes = 5'd16; in_max_bytes = 5'd16;
    in_a = rep16(16'h8000); in_b = rep16(16'h8000); in_acc = '0;
    @(negedge clk);
    sat_flag_clr = 1'b0; in_valid = 1'b0;
    check(sat_flag, "R7 set wins", 128'(sat_flag), 128'h1);
    clear_flag();
    check(!sat_flag, "R7 clear", 128'(sat_flag), 128'h0);

    // R9: rejected sizes
    send(2'b01, 1'b0, 1'b1, 5'd16, 5'd16, rep16(16'h8000), rep16(16'h8000), '0);
    prev = out_vec;
    send(2'b11, 1'b0, 1'b1, 5'd16, 5'd16, rep16(16'h1234), rep16(16'h1234),
         rep16(16'h5678));
    check(err_pulse && !out_valid && out_vec == prev && sat_flag,
          "R9 size 11", {out_vec[127:3], err_pulse, out_valid, sat_flag},
          {prev[127:3], 3'b101});
    @(negedge clk);
    check(!err_pulse, "R9 pulse width", 128'(err_pulse), 128'h0);
    clear_flag();
    send(2'b00, 1'b0, 1'b1, 5'd16, 5'd16, rep16(16'h8000), rep16(16'h8000), '0);
    check(err_pulse && !out_valid && !sat_flag, "R9 size 00",
          {err_pulse, out_valid, sat_flag}, 128'h4);

    // R10: back-pressure
    @(negedge clk); out_ready = 1'b0;
    send(2'b01, 1'b0, 1'b1, 5'd16, 5'd16, rep16(16'h4000), rep16(16'h4000), '0);
    @(negedge clk);
    in_valid = 1'b1; in_a = rep16(16'h0200); in_b = rep16(16'h0300);
    in_acc = rep16(16'h0100);
    repeat (3) @(negedge clk);
    check(out_valid && !in_ready && out_vec == rep16(16'h2000), "R10 hold",
          out_vec, rep16(16'h2000));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_vec == rep16(16'h010C), "R10 release", out_vec,
          rep16(16'h010C));
    @(negedge clk);
    check(!out_valid, "R10 drain", 128'(out_valid), 128'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule